// File: doc/BRIEF.md
# SDRAM refresh and power-down scheduler

This block decides when refresh and low-power commands go out to an SDRAM device on behalf of a memory controller. A free-running interval timer raises a refresh request at a programmable, coarse-grained interval. The block holds that request until the access path reports that its current access has finished. It then precharges all banks, waits a programmable precharge delay, issues auto-refresh and waits a programmable refresh-to-idle delay before it hands the bus back.

While the bus is idle, the block can drop the clock enable to put the device into precharge power-down. Leaving power-down costs one extra cycle before an access is granted. A software control bit moves the device into self-refresh and back out again. Auto-refresh requests are suppressed while the device refreshes itself.

The access path asks for the bus with `acc_req` and starts only in a cycle where `acc_gnt` is high. From the cycle after that grant, it holds `acc_busy` high until the access is complete. Row and column sequencing, data and initialization belong to other logic.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With interval field n, `ref_pending` rises every n*512+15 cycles. The first rise is seen exactly n*512+15 cycles after reset is released (15 for n=0).
- R2: While `acc_busy` is high, no precharge is issued and `acc_gnt` stays low. The first precharge-all appears one cycle after `acc_busy` falls with a request pending.
- R3: Precharge-all is encoded as (cs_n,ras_n,cas_n,we_n)=(0,0,1,0) with a10=1. With precharge field p, the auto-refresh command (0,0,0,1, cke=1) follows exactly p+2 cycles after the precharge cycle. Every cycle in between is a NOP (0,1,1,1).
- R4: With refresh-to-idle field t, `acc_gnt` goes high exactly t+1 cycles after the auto-refresh cycle, provided no new request is pending.
- R5: With power-down enabled, the block is idle with no request, no access and no self-refresh bit set. One cycle later `cmd_cke` is 0 and `fsm_state` is 1.
- R6: An `acc_req` seen during power-down gives one cycle with `cmd_cke`=1, a NOP, `acc_gnt`=0 and `fsm_state`=2. `acc_gnt` is high in the cycle after that.
- R7: Setting `cfg_self_ref` from idle starts a fixed sequence. The block issues precharge-all (`fsm_state`=7), then p+1 NOP cycles (`fsm_state`=8). It then issues the self-refresh command (0,0,0,1) with cke=0 (`fsm_state`=9). After that `cmd_cke` stays 0 (`fsm_state`=10). `ref_pending` stays 0 for as long as this lasts.
- R8: Clearing `cfg_self_ref` gives one cycle with cke=1 and a NOP (`fsm_state`=11). The refresh-to-idle wait follows (`fsm_state`=6, t cycles). The block then returns to idle (`fsm_state`=0).
- R9: Requests are not queued. However many intervals expire while an access is busy, one precharge and one auto-refresh follow its release.
- R10: `fsm_state` reports the controller state as a 4-bit code: 0 idle, 1 power-down, 2 power-down exit, 3 precharge, 4 precharge wait, 5 auto-refresh, 6 refresh-to-idle wait, 7 to 11 the self-refresh states listed in R7 and R8.
- R11: Directly after reset, `fsm_state` is 0, `cmd_cke` is 1, the command is a NOP and `ref_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ref_n | input | 6 | Refresh interval field n (n*512+15 cycles) |
| cfg_trp | input | 3 | Precharge-to-refresh field (n+1 wait cycles) |
| cfg_trc | input | 3 | Refresh-to-idle field (n wait cycles) |
| cfg_pd_en | input | 1 | Enables precharge power-down while idle |
| cfg_self_ref | input | 1 | 1 requests self-refresh, 0 requests exit |
| acc_req | input | 1 | Access path asks for the bus |
| acc_busy | input | 1 | Access path has an access in progress |
| acc_gnt | output | 1 | Access may start in this cycle |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_cke | output | 1 | Clock enable |
| cmd_a10 | output | 1 | Address bit 10 (all-bank select for precharge) |
| ref_pending | output | 1 | A refresh request is outstanding |
| fsm_state | output | 4 | Controller state code (R10) |

## Verification
The assertions take the access path at its word. `acc_busy` must be high from the cycle after a grant until the access ends. The configuration fields must not change while a refresh or self-refresh sequence is running. The bench changes configuration only while reset is held or while the block is idle. It raises `acc_busy` only when it wants to block refresh, never in the middle of a sequence. It drives requests and samples outputs on the falling edge, so each observed cycle is a whole number of clocks after a known command.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_PD       = 4'd1,
        ST_PD_EXIT  = 4'd2,
        ST_PRE      = 4'd3,
        ST_TRP      = 4'd4,
        ST_REF      = 4'd5,
        ST_TRC      = 4'd6,
        ST_SR_PRE   = 4'd7,
        ST_SR_TRP   = 4'd8,
        ST_SR_ENTER = 4'd9,
        ST_SR       = 4'd10,
        ST_SR_EXIT  = 4'd11
    } rfs_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
        logic a10;
    } rfs_cmd_t;

    function automatic rfs_cmd_t rfs_decode(rfs_state_e s);
        rfs_cmd_t c;
        c = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, cke: 1'b1, a10: 1'b0};
        case (s)
            ST_PRE, ST_SR_PRE: begin
                c.ras_n = 1'b0;
                c.we_n  = 1'b0;
                c.a10   = 1'b1;
            end
            ST_REF: begin
                c.ras_n = 1'b0;
                c.cas_n = 1'b0;
            end
            ST_SR_ENTER: begin
                c.ras_n = 1'b0;
                c.cas_n = 1'b0;
                c.cke   = 1'b0;
            end
            ST_PD, ST_SR: c.cke = 1'b0;
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic in_self_refresh(rfs_state_e s);
        return (s == ST_SR_PRE) || (s == ST_SR_TRP) || (s == ST_SR_ENTER)
            || (s == ST_SR) || (s == ST_SR_EXIT);
    endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
    parameter int REF_W = 6,
    parameter int SHIFT = 9,
    parameter int BASE  = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REF_W-1:0] ref_n,
    input  logic             block,
    input  logic             accept,
    output logic             pending
);
    localparam int CW = REF_W + SHIFT + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload_val;
    logic          expire;
    logic          pend_q;

    assign reload_val = (CW'(ref_n) << SHIFT) + CW'(BASE - 1);
    assign expire     = (cnt_q == '0);
    assign pending    = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= reload_val;
            pend_q <= 1'b0;
        end else begin
            cnt_q  <= expire ? reload_val : cnt_q - 1'b1;
            pend_q <= (pend_q & ~accept & ~block) | (expire & ~block);
        end
    end

    logic [CW-1:0] gap_q;
    logic [CW-1:0] ivl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= '0;
            ivl_q <= reload_val;
        end else if (expire) begin
            gap_q <= '0;
            ivl_q <= reload_val;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_interval: assert property (@(posedge clk) disable iff (rst)
        expire |-> (gap_q == ivl_q));

    a_r9_no_queue: assert property (@(posedge clk) disable iff (rst)
        (pend_q && expire && !accept && !block) |=> pend_q);

endmodule

// File: rtl/rfs_delay_timer.sv
module rfs_delay_timer #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             zero
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/rfs_ctrl_fsm.sv
module rfs_ctrl_fsm
    import rfs_pkg::*;
#(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DLY_W-1:0] cfg_trp,
    input  logic [DLY_W-1:0] cfg_trc,
    input  logic             cfg_pd_en,
    input  logic             cfg_self_ref,
    input  logic             acc_req,
    input  logic             acc_busy,
    input  logic             pending,
    input  logic             dly_zero,
    output rfs_state_e       state_q,
    output logic             accept,
    output logic             sr_block,
    output logic             dly_load,
    output logic [DLY_W-1:0] dly_val,
    output logic             acc_gnt
);
    rfs_state_e state_d;

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        dly_load = 1'b0;
        dly_val  = cfg_trp;
        case (state_q)
            ST_IDLE: begin
                if (acc_busy)
                    state_d = ST_IDLE;
                else if (cfg_self_ref)
                    state_d = ST_SR_PRE;
                else if (pending) begin
                    state_d = ST_PRE;
                    accept  = 1'b1;
                end else if (cfg_pd_en && !acc_req)
                    state_d = ST_PD;
            end
            ST_PD: begin
                if (acc_req || acc_busy || pending || cfg_self_ref || !cfg_pd_en)
                    state_d = ST_PD_EXIT;
            end
            ST_PD_EXIT: state_d = ST_IDLE;
            ST_PRE: begin
                state_d  = ST_TRP;
                dly_load = 1'b1;
            end
            ST_TRP: begin
                if (dly_zero)
                    state_d = ST_REF;
            end
            ST_REF, ST_SR_EXIT: begin
                if (cfg_trc == '0)
                    state_d = ST_IDLE;
                else begin
                    state_d  = ST_TRC;
                    dly_load = 1'b1;
                    dly_val  = cfg_trc - 1'b1;
                end
            end
            ST_TRC: begin
                if (dly_zero)
                    state_d = ST_IDLE;
            end
            ST_SR_PRE: begin
                state_d  = ST_SR_TRP;
                dly_load = 1'b1;
            end
            ST_SR_TRP: begin
                if (dly_zero)
                    state_d = ST_SR_ENTER;
            end
            ST_SR_ENTER: state_d = ST_SR;
            ST_SR: begin
                if (!cfg_self_ref)
                    state_d = ST_SR_EXIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    assign sr_block = in_self_refresh(state_q);
    assign acc_gnt  = (state_q == ST_IDLE) && !acc_busy && !pending && !cfg_self_ref;

    logic [DLY_W:0] since_pre_q;
    logic [DLY_W:0] since_ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre_q <= '0;
            since_ref_q <= '0;
        end else begin
            if (state_q == ST_PRE || state_q == ST_SR_PRE)
                since_pre_q <= '0;
            else if (state_q == ST_TRP || state_q == ST_SR_TRP)
                since_pre_q <= since_pre_q + 1'b1;
            if (state_q == ST_REF || state_q == ST_SR_EXIT)
                since_ref_q <= '0;
            else if (state_q == ST_TRC)
                since_ref_q <= since_ref_q + 1'b1;
        end
    end

    a_r2_idle_before_pre: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRE) |-> !$past(acc_busy));

    a_r3_trp_gap: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_REF || state_q == ST_SR_ENTER)
            |-> (since_pre_q == (DLY_W+1)'(cfg_trp) + 1'b1));

    a_r4_trc_gap: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && ($past(state_q) == ST_REF || $past(state_q) == ST_TRC))
            |-> (since_ref_q == (DLY_W+1)'(cfg_trc)));

    a_r6_pd_exit_cycle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> ($past(state_q) != ST_PD));

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
    import rfs_pkg::*;
#(
    parameter int REF_W = 6,
    parameter int DLY_W = 3,
    parameter int SHIFT = 9,
    parameter int BASE  = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REF_W-1:0] cfg_ref_n,
    input  logic [DLY_W-1:0] cfg_trp,
    input  logic [DLY_W-1:0] cfg_trc,
    input  logic             cfg_pd_en,
    input  logic             cfg_self_ref,
    input  logic             acc_req,
    input  logic             acc_busy,
    output logic             acc_gnt,
    output logic             cmd_cs_n,
    output logic             cmd_ras_n,
    output logic             cmd_cas_n,
    output logic             cmd_we_n,
    output logic             cmd_cke,
    output logic             cmd_a10,
    output logic             ref_pending,
    output logic [3:0]       fsm_state
);
    rfs_state_e       state;
    rfs_cmd_t         cmd;
    logic             accept;
    logic             sr_block;
    logic             dly_load;
    logic [DLY_W-1:0] dly_val;
    logic             dly_zero;

    rfs_interval_timer #(.REF_W(REF_W), .SHIFT(SHIFT), .BASE(BASE)) u_ivl (
        .clk     (clk),
        .rst     (rst),
        .ref_n   (cfg_ref_n),
        .block   (sr_block),
        .accept  (accept),
        .pending (ref_pending)
    );

    rfs_delay_timer #(.DLY_W(DLY_W)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (dly_val),
        .zero     (dly_zero)
    );

    rfs_ctrl_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cfg_trp      (cfg_trp),
        .cfg_trc      (cfg_trc),
        .cfg_pd_en    (cfg_pd_en),
        .cfg_self_ref (cfg_self_ref),
        .acc_req      (acc_req),
        .acc_busy     (acc_busy),
        .pending      (ref_pending),
        .dly_zero     (dly_zero),
        .state_q      (state),
        .accept       (accept),
        .sr_block     (sr_block),
        .dly_load     (dly_load),
        .dly_val      (dly_val),
        .acc_gnt      (acc_gnt)
    );

    assign cmd       = rfs_decode(state);
    assign cmd_cs_n  = cmd.cs_n;
    assign cmd_ras_n = cmd.ras_n;
    assign cmd_cas_n = cmd.cas_n;
    assign cmd_we_n  = cmd.we_n;
    assign cmd_cke   = cmd.cke;
    assign cmd_a10   = cmd.a10;
    assign fsm_state = state;

    a_r7_sr_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SR) |-> (!ref_pending && !cmd_cke));

    a_r5_gnt_only_idle: assert property (@(posedge clk) disable iff (rst)
        acc_gnt |-> (cmd_cke && !ref_pending && !acc_busy));

endmodule

// File: tb/sim_sdram_refresh_sched.sv
module sim_sdram_refresh_sched;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cfg_ref_n = 6'd0;
    logic [2:0] cfg_trp = 3'd0;
    logic [2:0] cfg_trc = 3'd0;
    logic       cfg_pd_en = 1'b0;
    logic       cfg_self_ref = 1'b0;
    logic       acc_req = 1'b0;
    logic       acc_busy = 1'b0;
    logic       acc_gnt, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_cke, cmd_a10;
    logic       ref_pending;
    logic [3:0] fsm_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [5:0] VEC [6] = '{
        {3'd0, 3'd0}, {3'd7, 3'd7}, {3'd3, 3'd0},
        {3'd0, 3'd5}, {3'd2, 3'd2}, {3'd5, 3'd1}
    };

    always #2.5 clk = ~clk;

    sdram_refresh_sched u0 (
        .clk(clk), .rst(rst), .cfg_ref_n(cfg_ref_n), .cfg_trp(cfg_trp),
        .cfg_trc(cfg_trc), .cfg_pd_en(cfg_pd_en), .cfg_self_ref(cfg_self_ref),
        .acc_req(acc_req), .acc_busy(acc_busy), .acc_gnt(acc_gnt),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_cke(cmd_cke), .cmd_a10(cmd_a10),
        .ref_pending(ref_pending), .fsm_state(fsm_state)
    );

    function automatic logic [3:0] cmd_bits();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    endfunction

    function automatic bit is_pre();
        return cmd_bits() == 4'b0010 && cmd_a10;
    endfunction

    function automatic bit is_ref();
        return cmd_bits() == 4'b0001 && cmd_cke;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset(input int rn, input int tp, input int tc, input bit pd, input bit busy);
        @(negedge clk);
        rst = 1'b1;
        cfg_ref_n = 6'(rn);
        cfg_trp = 3'(tp);
        cfg_trc = 3'(tc);
        cfg_pd_en = pd;
        cfg_self_ref = 1'b0;
        acc_req = 1'b0;
        acc_busy = busy;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pres, refs, bad;
        // Table of refresh delay settings: precharge gap (R3) and idle gap (R4)
        foreach (VEC[i]) begin
            int tp, tc, n, gap;
            tp = int'(VEC[i][5:3]);
            tc = int'(VEC[i][2:0]);
            do_reset(1, tp, tc, 1'b0, 1'b0);
            n = 0;
            while (!is_pre() && n < 600) begin tick(); n++; end
            check(is_pre(), "R3 precharge-all seen", int'(cmd_bits()), 2);
            gap = 0; bad = 0;
            do begin
                tick(); gap++;
                if (!is_ref() && cmd_bits() != 4'b0111) bad++;
            end while (!is_ref() && gap < 20);
            check(gap == tp + 2, "R3 precharge to refresh cycles", gap, tp + 2);
            check(bad == 0, "R3 nop between commands", bad, 0);
            gap = 0;
            do begin tick(); gap++; end while (!acc_gnt && gap < 20);
            check(gap == tc + 1, "R4 refresh to grant cycles", gap, tc + 1);
        end

        // R11 reset state, then R1 interval and R2 busy hold-off
        do_reset(0, 0, 0, 1'b0, 1'b1);
        check(fsm_state == 4'd0 && cmd_cke && cmd_bits() == 4'b0111 && !ref_pending,
              "R11 reset state", int'(fsm_state), 0);
        for (int k = 1; k <= 15; k++) begin
            tick();
            if (k == 14) check(ref_pending == 1'b0, "R1 no request before interval", ref_pending, 0);
            if (k == 15) check(ref_pending == 1'b1, "R1 request at 15 cycles", ref_pending, 1);
        end
        bad = 0;
        for (int k = 0; k < 5; k++) begin
            if (is_pre() || acc_gnt) bad++;
            tick();
        end
        check(bad == 0, "R2 no precharge or grant while busy", bad, 0);
        acc_busy = 1'b0;
        tick();
        check(is_pre(), "R2 precharge one cycle after busy drops", int'(cmd_bits()), 2);
        check(fsm_state == 4'd3, "R10 precharge state code", int'(fsm_state), 3);

        // R9 no queueing across two expired intervals
        do_reset(1, 0, 0, 1'b0, 1'b1);
        repeat (1200) tick();
        acc_busy = 1'b0;
        pres = 0; refs = 0;
        for (int k = 0; k < 30; k++) begin
            tick();
            if (is_pre()) pres++;
            if (is_ref()) refs++;
        end
        check(pres == 1, "R9 single precharge", pres, 1);
        check(refs == 1, "R9 single auto-refresh", refs, 1);

        // R5 / R6 power-down entry and exit
        do_reset(1, 0, 0, 1'b1, 1'b0);
        tick();
        check(!cmd_cke && fsm_state == 4'd1, "R5 power-down entry", int'(fsm_state), 1);
        tick();
        acc_req = 1'b1;
        tick();
        check(cmd_cke && !acc_gnt && fsm_state == 4'd2 && cmd_bits() == 4'b0111,
              "R6 exit cycle", int'(fsm_state), 2);
        tick();
        check(acc_gnt == 1'b1, "R6 grant after exit", acc_gnt, 1);
        acc_req = 1'b0;
        tick();
        check(!cmd_cke, "R5 re-enter power-down", cmd_cke, 0);

        // R7 / R8 self-refresh
        do_reset(0, 2, 1, 1'b0, 1'b0);
        cfg_self_ref = 1'b1;
        tick();
        check(is_pre() && fsm_state == 4'd7, "R7 precharge before self-refresh", int'(fsm_state), 7);
        bad = 0;
        for (int k = 0; k < 3; k++) begin
            tick();
            if (fsm_state != 4'd8 || cmd_bits() != 4'b0111) bad++;
        end
        check(bad == 0, "R7 precharge wait cycles", bad, 0);
        tick();
        check(cmd_bits() == 4'b0001 && !cmd_cke && fsm_state == 4'd9,
              "R7 self-refresh command", int'(fsm_state), 9);
        bad = 0;
        for (int k = 0; k < 45; k++) begin
            tick();
            if (cmd_cke || ref_pending || fsm_state != 4'd10) bad++;
        end
        check(bad == 0, "R7 stays in self-refresh, no request", bad, 0);
        cfg_self_ref = 1'b0;
        tick();
        check(cmd_cke && fsm_state == 4'd11 && cmd_bits() == 4'b0111,
              "R8 exit cycle", int'(fsm_state), 11);
        tick();
        check(fsm_state == 4'd6, "R8 refresh-to-idle wait", int'(fsm_state), 6);
        tick();
        check(fsm_state == 4'd0, "R8 back to idle", int'(fsm_state), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule